// File: doc/BRIEF.md
# Dual-Processor Mailbox Flag Controller

This block lets two processors that share one clock raise and retire per-channel "message waiting" flags for each other. There are two directions, A to B and B to A, and each direction has one flag per channel. A processor raises a flag in its outgoing direction to say that data for the peer is ready. The peer lowers that flag once it has consumed the data. The data itself lives in a separate shared memory. The simplex and ping-pong conventions that software builds on top of the flags are also outside this block.

Each processor has its own simple bus port, with a single-cycle write and a combinational read. Behind each port sit four registers: an interrupt-enable control word, a mask word, a write-only strobe word that raises or lowers flags, and a read-only copy of that processor's outgoing flags. Each processor receives two level interrupts. One says that an incoming channel holds a message. The other says that an outgoing channel has been emptied. Both are qualified per channel by the mask bits and globally by the enable bits. Software drops an interrupt by masking the channel or by changing the flag. There is no separate clear.

The asynchronous active-low reset is synchronised inside the block before it is used. The internal state therefore leaves reset two clock edges after `rst_n` rises.

Top module: `mbox_flag_ctrl`

## Requirements
- R1: After reset, every flag reads 0 (0 means free, 1 means occupied). Each mask register reads 0x003F003F, meaning every mask bit is 1. Each control register reads 0, and all four interrupts are low.
- R2: A write of the strobe word (offset 0x8) raises the flags in the writer's outgoing direction for every 1 in bits [21:16]. Bit 16+k selects channel k. The change is visible in the writer's status word (offset 0xC, bits [5:0]) from the next cycle. A 0 in these bits changes nothing.
- R3: A 1 in bit k of the strobe word, bits [5:0], lowers channel k of the incoming direction, which is the peer's outgoing flag. It never affects the writer's own outgoing flags.
- R4: When the sender raises a flag and the receiver lowers the same flag in the same cycle, the flag ends up raised.
- R5: The strobe word always reads as 0. Writes to the status offset are ignored.
- R6: The control word holds the RX-occupied enable in bit 0 and the TX-free enable in bit 1. The mask word holds the occupied-mask bits in [5:0] and the free-mask bits in [21:16]. Both words read back what was written, and all other bits read as 0.
- R7: A processor's RX-occupied interrupt is high exactly when its RX-occupied enable is 1 and some incoming flag is 1 with its occupied-mask bit at 0.
- R8: A processor's TX-free interrupt is high exactly when its TX-free enable is 1 and some outgoing flag is 0 with its free-mask bit at 0.
- R9: Both interrupts are levels. One cycle after a write of the mask, the control word or the strobe word, each interrupt shows the new condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_sel | input | 1 | Processor A bus access select |
| a_wr | input | 1 | Processor A write (1) or read (0) |
| a_addr | input | 4 | Processor A byte offset |
| a_wdata | input | 32 | Processor A write data |
| a_rdata | output | 32 | Processor A read data, same cycle |
| a_irq_txfree | output | 1 | Processor A outgoing-channel-emptied interrupt |
| a_irq_rxocc | output | 1 | Processor A incoming-message interrupt |
| b_sel | input | 1 | Processor B bus access select |
| b_wr | input | 1 | Processor B write (1) or read (0) |
| b_addr | input | 4 | Processor B byte offset |
| b_wdata | input | 32 | Processor B write data |
| b_rdata | output | 32 | Processor B read data, same cycle |
| b_irq_txfree | output | 1 | Processor B outgoing-channel-emptied interrupt |
| b_irq_rxocc | output | 1 | Processor B incoming-message interrupt |

## Verification
The bench targets the cross-port routing of the strobe word. A design that sends a processor's lower bits to its own outgoing flags would let a sender retire its own message, and the status word would drop when the bench expects it to hold. A simultaneous raise from one port and lower from the other is driven on two channels at once. A design that lets the lower win would lose a freshly posted message on the raised channel. A design that ignores the lower entirely would leave the other channel stuck occupied. Interrupt tests walk each interrupt through its mask bit, its enable and both flag values on one channel at a time, so an inverted mask polarity, a swapped enable bit or a wrong direction shows up as an interrupt at the wrong level.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  // Byte offsets of the per-port words
  localparam int OFF_CTRL   = 'h0;
  localparam int OFF_MASK   = 'h4;
  localparam int OFF_STROBE = 'h8;
  localparam int OFF_STATUS = 'hC;
  // Field positions
  localparam int RX_EN_BIT    = 0;
  localparam int TX_EN_BIT    = 1;
  localparam int HI_FIELD_LSB = 16;  // free-mask field and raise field
endpackage

// File: rtl/mbox_rst_sync.sv
module mbox_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_int_n = sync_q[1];
endmodule

// File: rtl/mbox_port_regs.sv
module mbox_port_regs #(
  parameter int NUM_CH = 6,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NUM_CH-1:0] out_flags,
  output logic [DATA_W-1:0] rdata,
  output logic              rx_en,
  output logic              tx_en,
  output logic [NUM_CH-1:0] occ_mask,
  output logic [NUM_CH-1:0] free_mask,
  output logic [NUM_CH-1:0] raise_req,
  output logic [NUM_CH-1:0] lower_req
);
  import mbox_pkg::*;

  logic              hit_ctrl, hit_mask, hit_strobe, hit_status;
  logic              ctrl_we, mask_we, strobe_we;
  logic              rx_en_q, tx_en_q, rx_en_d, tx_en_d;
  logic [NUM_CH-1:0] occ_q, free_q, occ_d, free_d;
  logic              unused_wdata;

  assign unused_wdata = ^wdata;

  // Decode
  always_comb begin
    hit_ctrl   = (addr == ADDR_W'(OFF_CTRL));
    hit_mask   = (addr == ADDR_W'(OFF_MASK));
    hit_strobe = (addr == ADDR_W'(OFF_STROBE));
    hit_status = (addr == ADDR_W'(OFF_STATUS));
    ctrl_we    = sel && wr && hit_ctrl;
    mask_we    = sel && wr && hit_mask;
    strobe_we  = sel && wr && hit_strobe;
  end

  // Next state
  always_comb begin
    rx_en_d = wdata[RX_EN_BIT];
    tx_en_d = wdata[TX_EN_BIT];
    occ_d   = wdata[NUM_CH-1:0];
    free_d  = wdata[HI_FIELD_LSB +: NUM_CH];
  end

  // Registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en_q <= 1'b0;
      tx_en_q <= 1'b0;
      occ_q   <= '1;
      free_q  <= '1;
    end else begin
      if (ctrl_we) begin
        rx_en_q <= rx_en_d;
        tx_en_q <= tx_en_d;
      end
      if (mask_we) begin
        occ_q  <= occ_d;
        free_q <= free_d;
      end
    end
  end

  // Strobe word produces one-cycle requests only
  always_comb begin
    raise_req = strobe_we ? wdata[HI_FIELD_LSB +: NUM_CH] : '0;
    lower_req = strobe_we ? wdata[NUM_CH-1:0]             : '0;
  end

  // Read path; strobe offset falls through to zero
  always_comb begin
    rdata = '0;
    if (sel && !wr) begin
      if (hit_ctrl) begin
        rdata[RX_EN_BIT] = rx_en_q;
        rdata[TX_EN_BIT] = tx_en_q;
      end else if (hit_mask) begin
        rdata[NUM_CH-1:0]              = occ_q;
        rdata[HI_FIELD_LSB +: NUM_CH]  = free_q;
      end else if (hit_status) begin
        rdata[NUM_CH-1:0] = out_flags;
      end
    end
  end

  assign rx_en     = rx_en_q;
  assign tx_en     = tx_en_q;
  assign occ_mask  = occ_q;
  assign free_mask = free_q;
endmodule

// File: rtl/mbox_flag_bank.sv
module mbox_flag_bank #(
  parameter int NUM_CH = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] raise_req,
  input  logic [NUM_CH-1:0] lower_req,
  output logic [NUM_CH-1:0] flags
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic flag_q, flag_d, flag_en;

    always_comb begin
      flag_en = raise_req[ch] | lower_req[ch];
      flag_d  = raise_req[ch];  // raise dominates a same-cycle lower
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q <= 1'b0;
      else if (flag_en) flag_q <= flag_d;
    end

    assign flags[ch] = flag_q;
  end
endmodule

// File: rtl/mbox_irq_gen.sv
module mbox_irq_gen #(
  parameter int NUM_CH = 6
) (
  input  logic [NUM_CH-1:0] in_flags,
  input  logic [NUM_CH-1:0] out_flags,
  input  logic [NUM_CH-1:0] occ_mask,
  input  logic [NUM_CH-1:0] free_mask,
  input  logic              rx_en,
  input  logic              tx_en,
  output logic              irq_rxocc,
  output logic              irq_txfree
);
  logic [NUM_CH-1:0] rx_hits, tx_hits;

  always_comb begin
    rx_hits    = in_flags & ~occ_mask;
    tx_hits    = ~out_flags & ~free_mask;
    irq_rxocc  = rx_en & (|rx_hits);
    irq_txfree = tx_en & (|tx_hits);
  end
endmodule

// File: rtl/mbox_flag_ctrl.sv
module mbox_flag_ctrl #(
  parameter int NUM_CH = 6,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_sel,
  input  logic              a_wr,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_irq_txfree,
  output logic              a_irq_rxocc,
  input  logic              b_sel,
  input  logic              b_wr,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_irq_txfree,
  output logic              b_irq_rxocc
);
  logic              rst_int_n;
  logic [NUM_CH-1:0] ab_flags, ba_flags;
  logic [NUM_CH-1:0] a_raise, a_lower, b_raise, b_lower;
  logic [NUM_CH-1:0] a_occ_m, a_free_m, b_occ_m, b_free_m;
  logic              a_rx_en, a_tx_en, b_rx_en, b_tx_en;

  mbox_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_int_n(rst_int_n));

  mbox_port_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port_a (
    .clk(clk), .rst_n(rst_int_n), .sel(a_sel), .wr(a_wr), .addr(a_addr),
    .wdata(a_wdata), .out_flags(ab_flags), .rdata(a_rdata),
    .rx_en(a_rx_en), .tx_en(a_tx_en), .occ_mask(a_occ_m), .free_mask(a_free_m),
    .raise_req(a_raise), .lower_req(a_lower));

  mbox_port_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port_b (
    .clk(clk), .rst_n(rst_int_n), .sel(b_sel), .wr(b_wr), .addr(b_addr),
    .wdata(b_wdata), .out_flags(ba_flags), .rdata(b_rdata),
    .rx_en(b_rx_en), .tx_en(b_tx_en), .occ_mask(b_occ_m), .free_mask(b_free_m),
    .raise_req(b_raise), .lower_req(b_lower));

  // A->B flags: raised by A, lowered by B; B->A the other way round
  mbox_flag_bank #(.NUM_CH(NUM_CH)) u_flags_ab (
    .clk(clk), .rst_n(rst_int_n), .raise_req(a_raise), .lower_req(b_lower),
    .flags(ab_flags));

  mbox_flag_bank #(.NUM_CH(NUM_CH)) u_flags_ba (
    .clk(clk), .rst_n(rst_int_n), .raise_req(b_raise), .lower_req(a_lower),
    .flags(ba_flags));

  mbox_irq_gen #(.NUM_CH(NUM_CH)) u_irq_a (
    .in_flags(ba_flags), .out_flags(ab_flags), .occ_mask(a_occ_m),
    .free_mask(a_free_m), .rx_en(a_rx_en), .tx_en(a_tx_en),
    .irq_rxocc(a_irq_rxocc), .irq_txfree(a_irq_txfree));

  mbox_irq_gen #(.NUM_CH(NUM_CH)) u_irq_b (
    .in_flags(ab_flags), .out_flags(ba_flags), .occ_mask(b_occ_m),
    .free_mask(b_free_m), .rx_en(b_rx_en), .tx_en(b_tx_en),
    .irq_rxocc(b_irq_rxocc), .irq_txfree(b_irq_txfree));
endmodule

// File: rtl/mbox_flag_ctrl_chk.sv
module mbox_flag_ctrl_chk #(
  parameter int NUM_CH = 6,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic              a_sel,
  input logic              a_wr,
  input logic [ADDR_W-1:0] a_addr,
  input logic [DATA_W-1:0] a_wdata,
  input logic [DATA_W-1:0] a_rdata,
  input logic              b_sel,
  input logic              b_wr,
  input logic [ADDR_W-1:0] b_addr,
  input logic [DATA_W-1:0] b_wdata,
  input logic              a_irq_txfree,
  input logic              b_irq_rxocc,
  input logic [NUM_CH-1:0] ab_flags,
  input logic [NUM_CH-1:0] ba_flags
);
  import mbox_pkg::*;

  logic              a_str, b_str;
  logic [NUM_CH-1:0] a_up, b_dn, b_up, a_dn;
  logic              unused_chk;

  assign unused_chk = ^{a_wdata, b_wdata};
  assign a_str = a_sel && a_wr && (a_addr == ADDR_W'(OFF_STROBE));
  assign b_str = b_sel && b_wr && (b_addr == ADDR_W'(OFF_STROBE));
  assign a_up  = a_str ? a_wdata[HI_FIELD_LSB +: NUM_CH] : '0;
  assign a_dn  = a_str ? a_wdata[NUM_CH-1:0] : '0;
  assign b_up  = b_str ? b_wdata[HI_FIELD_LSB +: NUM_CH] : '0;
  assign b_dn  = b_str ? b_wdata[NUM_CH-1:0] : '0;

  assert_raise_marks_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (a_up != '0) |=> ((ab_flags & $past(a_up)) == $past(a_up)));

  assert_lower_frees_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((b_dn & ~a_up) != '0) |=> ((ab_flags & $past(b_dn & ~a_up)) == '0));

  assert_flags_hold_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!a_str && !b_str) |=> ($stable(ab_flags) && $stable(ba_flags)));

  assert_raise_wins_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((a_up & b_dn) != '0) |=> ((ab_flags & $past(a_up & b_dn)) == $past(a_up & b_dn)));

  assert_strobe_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (a_sel && !a_wr && (a_addr == ADDR_W'(OFF_STROBE))) |-> (a_rdata == '0));

  assert_rxocc_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    b_irq_rxocc |-> (ab_flags != '0));

  assert_txfree_needs_free_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    a_irq_txfree |-> (ab_flags != '1));

  assert_ba_raise_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((b_up & ~a_dn) != '0) |=> ((ba_flags & $past(b_up)) == $past(b_up)));
endmodule

bind mbox_flag_ctrl mbox_flag_ctrl_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_int_n(rst_int_n),
  .a_sel(a_sel), .a_wr(a_wr), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
  .b_sel(b_sel), .b_wr(b_wr), .b_addr(b_addr), .b_wdata(b_wdata),
  .a_irq_txfree(a_irq_txfree), .b_irq_rxocc(b_irq_rxocc),
  .ab_flags(ab_flags), .ba_flags(ba_flags));

// File: tb/mbox_flag_ctrl_tb.sv
`timescale 1ns/1ps
module mbox_flag_ctrl_tb_top;
  localparam int NUM_CH = 6;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] A_CTRL = 4'h0, A_MASK = 4'h4, A_STR = 4'h8, A_STAT = 4'hC;

  logic clk = 1'b0;
  logic rst_n;
  logic a_sel, a_wr, b_sel, b_wr;
  logic [ADDR_W-1:0] a_addr, b_addr;
  logic [DATA_W-1:0] a_wdata, b_wdata, a_rdata, b_rdata;
  logic a_irq_txfree, a_irq_rxocc, b_irq_txfree, b_irq_rxocc;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  mbox_flag_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .a_sel(a_sel), .a_wr(a_wr), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .a_irq_txfree(a_irq_txfree), .a_irq_rxocc(a_irq_rxocc),
    .b_sel(b_sel), .b_wr(b_wr), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata),
    .b_irq_txfree(b_irq_txfree), .b_irq_rxocc(b_irq_rxocc));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Write on one port (0 = A, 1 = B); completes one negedge after the write edge
  task automatic wr(input bit port, input logic [ADDR_W-1:0] ad, input logic [31:0] d);
    @(negedge clk);
    if (!port) begin a_sel = 1; a_wr = 1; a_addr = ad; a_wdata = d; end
    else       begin b_sel = 1; b_wr = 1; b_addr = ad; b_wdata = d; end
    @(negedge clk);
    a_sel = 0; a_wr = 0; b_sel = 0; b_wr = 0;
  endtask

  task automatic wr_both(input logic [31:0] da, input logic [31:0] db);
    @(negedge clk);
    a_sel = 1; a_wr = 1; a_addr = A_STR; a_wdata = da;
    b_sel = 1; b_wr = 1; b_addr = A_STR; b_wdata = db;
    @(negedge clk);
    a_sel = 0; a_wr = 0; b_sel = 0; b_wr = 0;
  endtask

  task automatic rd(input bit port, input logic [ADDR_W-1:0] ad, output logic [31:0] d);
    @(negedge clk);
    if (!port) begin a_sel = 1; a_wr = 0; a_addr = ad; end
    else       begin b_sel = 1; b_wr = 0; b_addr = ad; end
    #0.5;
    d = port ? b_rdata : a_rdata;
    a_sel = 0; b_sel = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(0, A_CTRL, v); chk("R1 A ctrl", v, 32'h0);
    rd(1, A_MASK, v); chk("R1 B mask", v, 32'h003F003F);
    rd(0, A_STAT, v); chk("R1 A status", v, 32'h0);
    rd(1, A_STAT, v); chk("R1 B status", v, 32'h0);
    chk("R1 irqs", {28'h0, a_irq_txfree, a_irq_rxocc, b_irq_txfree, b_irq_rxocc}, 32'h0);
  endtask

  task automatic t_raise_lower();
    logic [31:0] v;
    wr(0, A_STR, 32'h0009_0000);
    rd(0, A_STAT, v); chk("R2 A raise ch0,ch3", v, 32'h09);
    rd(1, A_STAT, v); chk("R2 B status untouched", v, 32'h00);
    wr(0, A_STR, 32'h0);
    rd(0, A_STAT, v); chk("R2 zero write no effect", v, 32'h09);
    wr(0, A_STR, 32'h0000_0001);
    rd(0, A_STAT, v); chk("R3 own lower ignored", v, 32'h09);
    wr(1, A_STR, 32'h0000_0001);
    rd(0, A_STAT, v); chk("R3 B lowers A ch0", v, 32'h08);
    wr(1, A_STR, 32'h0020_0000);
    rd(1, A_STAT, v); chk("R2 B raise ch5", v, 32'h20);
    wr(0, A_STR, 32'h0000_0020);
    rd(1, A_STAT, v); chk("R3 A lowers B ch5", v, 32'h00);
  endtask

  task automatic t_raise_wins();
    logic [31:0] v;
    wr_both(32'h0002_0000, 32'h0000_000A);  // A raises ch1, B lowers ch1 and ch3
    rd(0, A_STAT, v); chk("R4 raise wins ch1, ch3 lowered", v, 32'h02);
  endtask

  task automatic t_readonly();
    logic [31:0] v;
    rd(0, A_STR, v); chk("R5 strobe reads zero", v, 32'h0);
    wr(0, A_STAT, 32'h0000_003F);
    rd(0, A_STAT, v); chk("R5 status write ignored", v, 32'h02);
    wr(0, A_MASK, 32'hFFFF_FFFF);
    rd(0, A_MASK, v); chk("R6 mask readback", v, 32'h003F003F);
    wr(0, A_CTRL, 32'hFFFF_FFFF);
    rd(0, A_CTRL, v); chk("R6 ctrl readback", v, 32'h3);
    wr(0, A_CTRL, 32'h0);
    rd(0, A_CTRL, v); chk("R6 ctrl cleared", v, 32'h0);
  endtask

  task automatic t_irq_rx();
    wr(1, A_CTRL, 32'h1);
    chk("R7 masked, no rxocc", {31'h0, b_irq_rxocc}, 32'h0);
    wr(1, A_MASK, 32'h003F_003D);
    chk("R7 unmasked ch1 rxocc", {31'h0, b_irq_rxocc}, 32'h1);
    chk("R8 B txfree stays low", {31'h0, b_irq_txfree}, 32'h0);
    wr(1, A_STR, 32'h0000_0002);
    chk("R7 lowered, rxocc off", {31'h0, b_irq_rxocc}, 32'h0);
    wr(0, A_STR, 32'h0002_0000);
    chk("R9 re-raise, rxocc on", {31'h0, b_irq_rxocc}, 32'h1);
    wr(1, A_MASK, 32'h003F_003F);
    chk("R9 mask drops rxocc", {31'h0, b_irq_rxocc}, 32'h0);
    wr(1, A_MASK, 32'h003F_003D);
    wr(1, A_CTRL, 32'h2);
    chk("R7 rx enable off", {31'h0, b_irq_rxocc}, 32'h0);
    wr(1, A_CTRL, 32'h0);
  endtask

  task automatic t_irq_tx();
    wr(0, A_CTRL, 32'h2);
    wr(0, A_MASK, 32'h003D_003F);
    chk("R8 ch1 occupied, no txfree", {31'h0, a_irq_txfree}, 32'h0);
    chk("R7 A rxocc low", {31'h0, a_irq_rxocc}, 32'h0);
    wr(1, A_STR, 32'h0000_0002);
    chk("R8 ch1 freed, txfree", {31'h0, a_irq_txfree}, 32'h1);
    wr(0, A_STR, 32'h0002_0000);
    chk("R9 ch1 raised, txfree off", {31'h0, a_irq_txfree}, 32'h0);
    wr(0, A_MASK, 32'h003C_003F);
    chk("R8 ch0 unmasked free", {31'h0, a_irq_txfree}, 32'h1);
    wr(0, A_CTRL, 32'h1);
    chk("R8 tx enable off", {31'h0, a_irq_txfree}, 32'h0);
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; a_sel = 0; a_wr = 0; b_sel = 0; b_wr = 0;
    a_addr = '0; b_addr = '0; a_wdata = '0; b_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_raise_lower();
    t_raise_wins();
    t_readonly();
    t_irq_rx();
    t_irq_tx();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule